// File: doc/BRIEF.md
# Banked General Register File

This block is the integer register file of a 32-bit processor core. Software sees sixteen logical registers. The file holds twenty-four physical words. The lower half of the logical namespace, indices 0 to 7, exists twice: once in bank 0 and once in bank 1. The upper half, indices 8 to 15, is a single shared set. Two status inputs choose the active bank. Bank 1 is active only when the privileged-mode flag and the bank-select flag are both high. In every other combination bank 0 is active.

Ordinary instructions use two combinational read ports and one synchronous write port, and all three follow the active bank. Privileged instructions that must reach the inactive copy of the lower registers use a second path, with one read port and one write port. On that path indices 0 to 7 always resolve to the bank opposite the active one. Indices 8 to 15 resolve to the same shared words as on the normal path. Decoding the instructions and checking privilege are the caller's job.

Top module: `bank_regfile`

## Requirements
- R1: While `rst_n` is low, every physical word is cleared to zero, so all read ports return 0 from the clock edge after reset is sampled low.
- R2: The active bank is 1 only when `priv_mode` and `bank_sel` are both 1. The combinations 00, 01 and 10 all select bank 0.
- R3: On the normal ports, logical indices 8 to 15 reach the same storage whatever the status inputs are.
- R4: On the normal ports, logical indices 0 to 7 reach bank-0 words when bank 0 is active and separate bank-1 words when bank 1 is active.
- R5: On the alternate path, logical indices 0 to 7 reach the bank opposite the active one. With both status inputs low, an alternate write to index i is read back by the normal ports only after bank 1 becomes active.
- R6: A write occurs only on a rising clock edge with its enable high. With both enables low, the stored contents do not change, whatever is on the write index and data inputs.
- R7: Reads are combinational. A read of the word being written in the same cycle returns the old value, and the new value appears after the edge.
- R8: When the normal and alternate write ports target the same physical word in one cycle, the normal port's data is stored.
- R9: On the alternate path, logical indices 8 to 15 reach the same shared words as the normal ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| priv_mode | input | 1 | Privileged-mode status flag |
| bank_sel | input | 1 | Register-bank status flag |
| rd_a_idx | input | 4 | Logical index for normal read port A |
| rd_a_data | output | 32 | Data from normal read port A |
| rd_b_idx | input | 4 | Logical index for normal read port B |
| rd_b_data | output | 32 | Data from normal read port B |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 4 | Normal write logical index |
| wr_data | input | 32 | Normal write data |
| alt_rd_idx | input | 4 | Logical index for the alternate-bank read |
| alt_rd_data | output | 32 | Data from the alternate-bank read |
| alt_wr_en | input | 1 | Alternate-bank write enable |
| alt_wr_idx | input | 4 | Alternate-bank write logical index |
| alt_wr_data | input | 32 | Alternate-bank write data |

## Verification
The bound checker watches five things on every cycle.
- Contents are zero after reset.
- Read data holds when no write is enabled and the index and status inputs are steady.
- A normal or an alternate write is visible at a matching read one cycle later.
- Normal and alternate reads of an upper index agree.
- The normal port wins when both writes hit the same upper word.

Some behaviours depend on history across mode changes, so only the bench's scenarios can show them. The first is that the four status combinations map onto exactly one bank-1 case. The second is that alternate writes land in the bank the normal ports reach only after a bank switch. The third is that a same-cycle read returns the old word. The bench's model checks these on every clock under directed and random traffic.

// File: rtl/bgrf_pkg.sv
package bgrf_pkg;

  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_LOG_REGS = 16;
  localparam int unsigned DEF_BANKED   = 8;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;

endpackage

// File: rtl/bgrf_bank_decode.sv
module bgrf_bank_decode
  import bgrf_pkg::*;
(
  input  logic  priv_mode,
  input  logic  bank_sel,
  output bank_e act_bank,
  output bank_e alt_bank
);

  always_comb begin
    if (priv_mode && bank_sel) begin
      act_bank = BANK_HI;
      alt_bank = BANK_LO;
    end else begin
      act_bank = BANK_LO;
      alt_bank = BANK_HI;
    end
  end

endmodule

// File: rtl/bgrf_index_map.sv
module bgrf_index_map
  import bgrf_pkg::*;
#(
  parameter int unsigned LOG_REGS = DEF_LOG_REGS,
  parameter int unsigned BANKED   = DEF_BANKED,
  parameter int unsigned LIDX_W   = $clog2(DEF_LOG_REGS),
  parameter int unsigned PIDX_W   = $clog2(DEF_LOG_REGS + DEF_BANKED)
) (
  input  logic [LIDX_W-1:0] lidx,
  input  bank_e             bank,
  output logic [PIDX_W-1:0] pidx
);

  logic is_banked;

  always_comb begin
    is_banked = (int'(lidx) < int'(BANKED));
    if (is_banked && (bank == BANK_HI)) begin
      pidx = PIDX_W'(int'(lidx) + int'(LOG_REGS));
    end else begin
      pidx = PIDX_W'(lidx);
    end
  end

endmodule

// File: rtl/bgrf_storage.sv
module bgrf_storage #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PHYS_REGS = 24,
  parameter int unsigned PIDX_W    = 5,
  parameter int unsigned NRD       = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [PIDX_W-1:0]              wr_phys,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           alt_en,
  input  logic [PIDX_W-1:0]              alt_phys,
  input  logic [DATA_W-1:0]              alt_data,
  input  logic [NRD-1:0][PIDX_W-1:0]     rd_phys,
  output logic [NRD-1:0][DATA_W-1:0]     rd_data
);

  logic [DATA_W-1:0] slot_q [PHYS_REGS];

  for (genvar s = 0; s < PHYS_REGS; s++) begin : g_slot
    logic              hit_main;
    logic              hit_alt;
    logic              slot_en;
    logic [DATA_W-1:0] slot_d;

    always_comb begin
      hit_main = wr_en  && (wr_phys  == PIDX_W'(s));
      hit_alt  = alt_en && (alt_phys == PIDX_W'(s));
      slot_en  = hit_main || hit_alt;
      slot_d   = hit_main ? wr_data : alt_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (slot_en) begin
        slot_q[s] <= slot_d;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = slot_q[rd_phys[p]];
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bgrf_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned LOG_REGS = DEF_LOG_REGS,
  parameter int unsigned BANKED   = DEF_BANKED,
  localparam int unsigned LIDX_W  = $clog2(LOG_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic              bank_sel,
  input  logic [LIDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [LIDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LIDX_W-1:0] alt_rd_idx,
  output logic [DATA_W-1:0] alt_rd_data,
  input  logic              alt_wr_en,
  input  logic [LIDX_W-1:0] alt_wr_idx,
  input  logic [DATA_W-1:0] alt_wr_data
);

  localparam int unsigned PHYS_REGS = LOG_REGS + BANKED;
  localparam int unsigned PIDX_W    = $clog2(PHYS_REGS);
  localparam int unsigned NRD       = 3;
  localparam int unsigned NMAP      = NRD + 2;
  // map slots: 0 rd_a, 1 rd_b, 2 alt read, 3 write, 4 alt write
  localparam logic [NMAP-1:0] ALT_MASK = NMAP'(5'b10100);

  bank_e act_bank;
  bank_e alt_bank;

  logic [NMAP-1:0][LIDX_W-1:0] map_lidx;
  logic [NMAP-1:0][PIDX_W-1:0] map_pidx;
  logic [NRD-1:0][DATA_W-1:0]  rd_bus;

  bgrf_bank_decode u_decode (
    .priv_mode (priv_mode),
    .bank_sel  (bank_sel),
    .act_bank  (act_bank),
    .alt_bank  (alt_bank)
  );

  assign map_lidx[0] = rd_a_idx;
  assign map_lidx[1] = rd_b_idx;
  assign map_lidx[2] = alt_rd_idx;
  assign map_lidx[3] = wr_idx;
  assign map_lidx[4] = alt_wr_idx;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    bgrf_index_map #(
      .LOG_REGS (LOG_REGS),
      .BANKED   (BANKED),
      .LIDX_W   (LIDX_W),
      .PIDX_W   (PIDX_W)
    ) u_map (
      .lidx (map_lidx[m]),
      .bank (ALT_MASK[m] ? alt_bank : act_bank),
      .pidx (map_pidx[m])
    );
  end

  bgrf_storage #(
    .DATA_W    (DATA_W),
    .PHYS_REGS (PHYS_REGS),
    .PIDX_W    (PIDX_W),
    .NRD       (NRD)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_phys  (map_pidx[3]),
    .wr_data  (wr_data),
    .alt_en   (alt_wr_en),
    .alt_phys (map_pidx[4]),
    .alt_data (alt_wr_data),
    .rd_phys  (map_pidx[NRD-1:0]),
    .rd_data  (rd_bus)
  );

  assign rd_a_data   = rd_bus[0];
  assign rd_b_data   = rd_bus[1];
  assign alt_rd_data = rd_bus[2];

endmodule

// File: rtl/bgrf_checker.sv
module bgrf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANKED = 8,
  parameter int unsigned LIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              priv_mode,
  input logic              bank_sel,
  input logic [LIDX_W-1:0] rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [LIDX_W-1:0] rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [LIDX_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [LIDX_W-1:0] alt_rd_idx,
  input logic [DATA_W-1:0] alt_rd_data,
  input logic              alt_wr_en,
  input logic [LIDX_W-1:0] alt_wr_idx,
  input logic [DATA_W-1:0] alt_wr_data
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_a_data == '0 && rd_b_data == '0 && alt_rd_data == '0));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(alt_wr_en) && $stable(rd_a_idx) &&
     $stable(priv_mode) && $stable(bank_sel)) |-> $stable(rd_a_data));

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_a_idx == $past(wr_idx) &&
     $stable(priv_mode) && $stable(bank_sel)) |-> rd_a_data == $past(wr_data));

  assert_alt_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alt_wr_en) && !$past(wr_en) && alt_rd_idx == $past(alt_wr_idx) &&
     $stable(priv_mode) && $stable(bank_sel)) |-> alt_rd_data == $past(alt_wr_data));

  assert_shared_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == alt_rd_idx && int'(rd_a_idx) >= int'(BANKED)) |-> rd_a_data == alt_rd_data);

  assert_normal_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && alt_wr_en && wr_idx == alt_wr_idx && int'(wr_idx) >= int'(BANKED)) &&
     rd_b_idx == $past(wr_idx)) |-> rd_b_data == $past(wr_data));

endmodule

bind bank_regfile bgrf_checker #(
  .DATA_W (DATA_W),
  .BANKED (BANKED),
  .LIDX_W (LIDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .priv_mode   (priv_mode),
  .bank_sel    (bank_sel),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .alt_rd_idx  (alt_rd_idx),
  .alt_rd_data (alt_rd_data),
  .alt_wr_en   (alt_wr_en),
  .alt_wr_idx  (alt_wr_idx),
  .alt_wr_data (alt_wr_data)
);

// File: tb/bank_regfile_bench.sv
`timescale 1ns/1ps
module bank_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv_mode, bank_sel;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, alt_rd_idx, alt_wr_idx;
  logic [31:0] rd_a_data, rd_b_data, alt_rd_data, wr_data, alt_wr_data;
  logic        wr_en, alt_wr_en;

  int checks = 0;
  int fails  = 0;

  // reference contents: lower bank 0, lower bank 1, shared upper
  logic [31:0] m_lo0 [8];
  logic [31:0] m_lo1 [8];
  logic [31:0] m_up  [8];

  always #5 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk (clk), .rst_n (rst_n), .priv_mode (priv_mode), .bank_sel (bank_sel),
    .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
    .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .alt_rd_idx (alt_rd_idx), .alt_rd_data (alt_rd_data),
    .alt_wr_en (alt_wr_en), .alt_wr_idx (alt_wr_idx), .alt_wr_data (alt_wr_data)
  );

  function automatic bit use_hi(bit alt);
    bit hi = priv_mode & bank_sel;
    return alt ? !hi : hi;
  endfunction

  function automatic logic [31:0] mread(bit alt, logic [3:0] idx);
    if (idx >= 4'd8) return m_up[idx - 4'd8];
    return use_hi(alt) ? m_lo1[idx[2:0]] : m_lo0[idx[2:0]];
  endfunction

  task automatic mwrite(bit alt, logic [3:0] idx, logic [31:0] d);
    if (idx >= 4'd8) m_up[idx - 4'd8] = d;
    else if (use_hi(alt)) m_lo1[idx[2:0]] = d;
    else m_lo0[idx[2:0]] = d;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_norm(logic [3:0] idx);
    if (wr_en && wr_idx == idx) return "R7";
    return (idx >= 4'd8) ? "R3" : "R4";
  endfunction

  function automatic string tag_alt(logic [3:0] idx);
    return (idx >= 4'd8) ? "R9" : "R5";
  endfunction

  // called just after a falling edge with inputs set
  task automatic tick(string tag);
    #1;
    chk(tag != "" ? tag : tag_norm(rd_a_idx), rd_a_data,   mread(0, rd_a_idx));
    chk(tag != "" ? tag : tag_norm(rd_b_idx), rd_b_data,   mread(0, rd_b_idx));
    chk(tag != "" ? tag : tag_alt(alt_rd_idx), alt_rd_data, mread(1, alt_rd_idx));
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_lo0[i] = '0; m_lo1[i] = '0; m_up[i] = '0; end
    end else begin
      if (alt_wr_en) mwrite(1, alt_wr_idx, alt_wr_data);
      if (wr_en)     mwrite(0, wr_idx, wr_data);   // R8: normal port last, so it wins
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    wr_en = 0; alt_wr_en = 0;
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog (R1..): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; priv_mode = 0; bank_sel = 0;
    rd_a_idx = 0; rd_b_idx = 0; alt_rd_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0;
    alt_wr_en = 0; alt_wr_idx = 0; alt_wr_data = 0;
    for (int i = 0; i < 8; i++) begin m_lo0[i] = '0; m_lo1[i] = '0; m_up[i] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);

    // R1: every index on every port reads zero under reset
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); alt_rd_idx = 4'(i);
      tick("R1");
    end
    rst_n = 1;

    // fill: bank 0 active, alternate path fills bank 1
    for (int i = 0; i < 16; i++) begin
      wr_en = 1; wr_idx = 4'(i); wr_data = 32'h1000_0000 + 32'(i);
      alt_wr_en = (i < 8); alt_wr_idx = 4'(i); alt_wr_data = 32'h2000_0000 + 32'(i);
      rd_a_idx = 4'(i); rd_b_idx = 4'(i); alt_rd_idx = 4'(i);
      tick("");
    end
    quiet();

    // R2: only priv_mode=1 with bank_sel=1 exposes bank 1 on the normal ports
    for (int c = 0; c < 4; c++) begin
      priv_mode = c[1]; bank_sel = c[0];
      for (int i = 0; i < 16; i++) begin
        rd_a_idx = 4'(i); rd_b_idx = 4'(i ^ 8); alt_rd_idx = 4'(i);
        tick("R2");
      end
    end
    priv_mode = 0; bank_sel = 0;

    // R8: both write ports on shared index 10
    wr_en = 1; wr_idx = 4'd10; wr_data = 32'hAAAA_0001;
    alt_wr_en = 1; alt_wr_idx = 4'd10; alt_wr_data = 32'hBBBB_0002;
    rd_b_idx = 4'd10;
    tick("R8");
    quiet();
    tick("R8");

    // R6: data and index present but enables low
    wr_idx = 4'd3; wr_data = 32'hFFFF_FFFF; alt_wr_idx = 4'd3; alt_wr_data = 32'hEEEE_EEEE;
    rd_a_idx = 4'd3; rd_b_idx = 4'd11; alt_rd_idx = 4'd3;
    tick("R6");
    tick("R6");

    // R7: same-cycle read returns the old word, new one after the edge
    wr_en = 1; wr_idx = 4'd5; wr_data = 32'h5555_1234; rd_a_idx = 4'd5;
    tick("R7");
    quiet();
    tick("R7");

    // random traffic with bank switching
    for (int n = 0; n < 3000; n++) begin
      priv_mode = 1'($urandom); bank_sel = 1'($urandom);
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom); alt_rd_idx = 4'($urandom);
      wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
      alt_wr_en = 1'($urandom);
      alt_wr_idx = ($urandom % 4 == 0) ? wr_idx : 4'($urandom);
      alt_wr_data = $urandom;
      tick("");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule